// File: doc/BRIEF.md
# Alarm-Aligned Periodic Pulse Generator

This block watches a running 64-bit nanosecond time value supplied by a separate time counter and compares it against two programmable alarm values. The first alarm starts a set of fixed-interval pulse trains, so every train is phase-aligned to a chosen instant, usually a whole-second boundary. The second alarm only raises a one-cycle event strobe. Channel 0 of the pulse generator also drives a pulse-per-second event strobe.

Software programs the alarms as two 32-bit words, low word first. Only the high-word write changes the compare value. Each channel's period register holds the wanted interval minus one nominal tick. That tick accounts for the one-cycle detection latency. The alarm is normally set one tick before the target boundary, which makes the first pulse appear exactly at the boundary. Writing alarm 1 again, or loading the time counter, sends every channel back to waiting for the alarm.

Top module: `alarm_pulse_gen`

## Requirements
- R1: After a synchronous active-low reset, every pulse output, `pps_evt_o` and `alarm2_evt_o` are 0, start-enable is 0, both alarms and all periods are 0, and every channel is waiting.
- R2: Register map on `wr_addr` with `wr_en` high:
  - address 0 bit 0 is start-enable;
  - address 1 stages the alarm 1 low word;
  - address 2 writes the alarm 1 high word and commits `{high, staged low}`;
  - addresses 3 and 4 do the same for alarm 2;
  - address 5+i sets the period of channel i from `wr_data[PERW-1:0]`.
- R3: An alarm matches in a cycle where the previous cycle's `now_ns` is below the compare value and the current `now_ns` is at or above it. No match is made in the first cycle after reset or in a cycle with `now_load` high. A compare value of 0 never matches.
- R4: An alarm 2 match sets `alarm2_evt_o` high for exactly the following cycle.
- R5: A channel stays idle until start-enable is 1 and alarm 1 matches. Its first pulse appears in the cycle after the matching cycle.
- R6: After the first pulse, a channel with period value P and tick k gives its next pulse when P more nanoseconds of count have passed after the pulse. A running remainder drops by k each cycle. When it reaches 0 or below, a pulse is emitted and P is added back. Each pulse is one cycle wide when P ≥ k.
- R7: Each channel uses its own period register. Both channels start on the same alarm 1 match.
- R8: `pps_evt_o` equals the channel 0 pulse in every cycle.
- R9: Clearing start-enable stops every channel in the following cycle. Setting it again does not restart the channels without a fresh alarm 1 match.
- R10: A write to the alarm 1 high word, or a cycle with `now_load` high, returns every channel to waiting and suppresses any pulse in the following cycle.
- R11: A write to an alarm low word alone leaves the active compare value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_ns | input | TW (64) | Current time count in nanoseconds |
| tick_ns | input | TICKW (32) | Nanoseconds the count advances per cycle |
| now_load | input | 1 | High in the cycle the time count takes a software-loaded value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register write address |
| wr_data | input | DW (32) | Register write data |
| pulse_o | output | NCH (2) | One-cycle pulses, one bit per channel |
| pps_evt_o | output | 1 | Pulse-per-second event strobe (channel 0) |
| alarm2_evt_o | output | 1 | Alarm 2 event strobe |

## Verification
The assertions assume three things about the inputs:
- `now_ns` never moves backwards except in a cycle flagged by `now_load`;
- `tick_ns` is nonzero;
- every period value is at least one tick.

If any of these is broken, a crossing could repeat or a channel could pulse on consecutive cycles. The stimulus keeps within these bounds. It always advances the count by the current tick and picks ticks from a small nonzero set. It builds each period as a whole number of at least three ticks plus a sub-tick remainder, less one tick. Backward jumps of the count are made only through load cycles.

// File: rtl/alarm_pulse_pkg.sv
// Shared constants for the alarm-aligned pulse generator: data widths and
// register addresses. Assumes the time value is exactly two data words wide.
package alarm_pulse_pkg;
    localparam int DW = 32;
    localparam int TW = 2 * DW;
    localparam int AW = 4;

    localparam logic [AW-1:0] ADR_CTRL  = 4'd0;
    localparam logic [AW-1:0] ADR_A1_LO = 4'd1;
    localparam logic [AW-1:0] ADR_A1_HI = 4'd2;
    localparam logic [AW-1:0] ADR_A2_LO = 4'd3;
    localparam logic [AW-1:0] ADR_A2_HI = 4'd4;
    localparam logic [AW-1:0] ADR_PER0  = 4'd5;

    typedef logic [TW-1:0] ns_t;
endpackage

// File: rtl/apg_regs.sv
// Configuration store: start-enable, two staged 64-bit alarms and one period
// per channel. Assumes PERW <= DW and ADR_PER0 + NCH fits in the address.
module apg_regs
    import alarm_pulse_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int PERW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    output logic                start_en_o,
    output ns_t                 alarm1_o,
    output ns_t                 alarm2_o,
    output logic [PERW-1:0]     period_o [NCH],
    output logic                alarm1_commit_o
);
    logic [DW-1:0] a1_lo_q, a2_lo_q;

    // Alarm 1 high-word write is the re-arm event for the channels.
    assign alarm1_commit_o = wr_en && (wr_addr == ADR_A1_HI);

    // Control bit, low-word staging and alarm commit on high-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_en_o <= 1'b0;
            a1_lo_q    <= '0;
            a2_lo_q    <= '0;
            alarm1_o   <= '0;
            alarm2_o   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CTRL:  start_en_o <= wr_data[0];
                ADR_A1_LO: a1_lo_q    <= wr_data;
                ADR_A1_HI: alarm1_o   <= {wr_data, a1_lo_q};
                ADR_A2_LO: a2_lo_q    <= wr_data;
                ADR_A2_HI: alarm2_o   <= {wr_data, a2_lo_q};
                default:   ;
            endcase
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_per
        localparam logic [AW-1:0] MY_ADR = ADR_PER0 + AW'(i);
        // Period register of channel i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                period_o[i] <= '0;
            else if (wr_en && (wr_addr == MY_ADR))
                period_o[i] <= wr_data[PERW-1:0];
        end
    end
endmodule

// File: rtl/apg_cross.sv
// Crossing detector: flags the cycle where the time value moves from below
// the compare value to at or above it. Assumes time only moves forward except
// in cycles marked by jump_i, which are never treated as crossings.
module apg_cross
    import alarm_pulse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ns_t  cur_i,
    input  logic jump_i,
    input  ns_t  cmp_i,
    output logic hit_o
);
    ns_t  prev_q;
    logic vld_q;

    assign hit_o = vld_q && !jump_i && (prev_q < cmp_i) && (cur_i >= cmp_i);

    // Remember the previous sample; it is valid from the second cycle on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            prev_q <= cur_i;
            vld_q  <= 1'b1;
        end
    end

    // R3: with an unchanged compare value, one crossing never repeats next cycle.
    a_r3_single_cross: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (!hit_o || (cmp_i != $past(cmp_i))));
endmodule

// File: rtl/apg_chan.sv
// One pulse channel. It waits for the start trigger, pulses, then counts a
// signed remainder down by the tick and pulses each time it reaches zero or
// below, adding the period back. Assumes tick_i > 0 and period_i >= tick_i.
module apg_chan #(
    parameter int PERW  = 32,
    parameter int TICKW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             rearm_i,
    input  logic             trig_i,
    input  logic [PERW-1:0]  period_i,
    input  logic [TICKW-1:0] tick_i,
    output logic             pulse_o
);
    localparam int REMW = ((PERW > TICKW) ? PERW : TICKW) + 2;

    logic                   run_q;
    logic signed [REMW-1:0] rem_q;
    logic signed [REMW-1:0] per_ext, tick_ext;
    logic                   due;

    assign per_ext  = {{(REMW-PERW){1'b0}}, period_i};
    assign tick_ext = {{(REMW-TICKW){1'b0}}, tick_i};
    assign due      = rem_q[REMW-1] || (rem_q == '0);

    // Wait / run state machine with remainder accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || rearm_i) begin
            run_q   <= 1'b0;
            rem_q   <= '0;
            pulse_o <= 1'b0;
        end else if (!run_q) begin
            pulse_o <= trig_i;
            if (trig_i) begin
                run_q <= 1'b1;
                rem_q <= per_ext;
            end
        end else if (due) begin
            pulse_o <= 1'b1;
            rem_q   <= rem_q + per_ext;
        end else begin
            pulse_o <= 1'b0;
            rem_q   <= rem_q - tick_ext;
        end
    end

    // R9: a cleared enable silences the output the next cycle.
    a_r9_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pulse_o);
    // R10: a re-arm cycle is followed by a quiet output.
    a_r10_rearm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> !pulse_o);
    // R5: leaving the waiting state always comes with the first pulse.
    a_r5_first_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> pulse_o);
    // R5: no pulse while the channel is waiting.
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> run_q);
endmodule

// File: rtl/alarm_pulse_gen.sv
// Top of the alarm-aligned pulse generator. Ties the register store, two
// crossing detectors and NCH pulse channels together. Assumes now_ns is a
// nanosecond count that advances by tick_ns per cycle except on load cycles.
module alarm_pulse_gen
    import alarm_pulse_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int PERW  = 32,
    parameter int TICKW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    now_ns,
    input  logic [TICKW-1:0] tick_ns,
    input  logic             now_load,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [NCH-1:0]   pulse_o,
    output logic             pps_evt_o,
    output logic             alarm2_evt_o
);
    logic            start_en, a1_commit, hit1, hit2, rearm;
    ns_t             alarm1, alarm2;
    logic [PERW-1:0] period [NCH];

    apg_regs #(.NCH(NCH), .PERW(PERW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start_en_o(start_en), .alarm1_o(alarm1),
        .alarm2_o(alarm2), .period_o(period), .alarm1_commit_o(a1_commit));

    apg_cross u_cross1 (
        .clk(clk), .rst_n(rst_n), .cur_i(now_ns), .jump_i(now_load),
        .cmp_i(alarm1), .hit_o(hit1));

    apg_cross u_cross2 (
        .clk(clk), .rst_n(rst_n), .cur_i(now_ns), .jump_i(now_load),
        .cmp_i(alarm2), .hit_o(hit2));

    assign rearm = a1_commit || now_load;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        apg_chan #(.PERW(PERW), .TICKW(TICKW)) u_chan (
            .clk(clk), .rst_n(rst_n), .en_i(start_en), .rearm_i(rearm),
            .trig_i(hit1), .period_i(period[i]), .tick_i(tick_ns),
            .pulse_o(pulse_o[i]));
    end

    // Alarm 2 event strobe, registered one cycle after the crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) alarm2_evt_o <= 1'b0;
        else        alarm2_evt_o <= hit2;
    end

    assign pps_evt_o = pulse_o[0];

    // R4: the alarm 2 strobe follows a sample that reached the alarm value.
    a_r4_evt_reached: assert property (@(posedge clk) disable iff (!rst_n)
        alarm2_evt_o |-> ($past(now_ns) >= $past(alarm2)));
endmodule

// File: tb/sim_alarm_pulse_gen.sv
module sim_alarm_pulse_gen;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tns = 64'd0;
    logic [31:0] tick = 32'd8;
    logic        cnt_wr = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [NCH-1:0] pulse;
    logic        pps, a2evt;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    alarm_pulse_gen u0 (
        .clk(clk), .rst_n(rst_n), .now_ns(tns), .tick_ns(tick),
        .now_load(cnt_wr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pulse_o(pulse), .pps_evt_o(pps), .alarm2_evt_o(a2evt));

    // Reference model, built from the requirements.
    bit          m_en, m_vld;
    logic [63:0] m_a1, m_a2, m_prev;
    logic [31:0] m_a1lo, m_a2lo;
    logic [31:0] m_per [NCH];
    bit          m_run [NCH];
    longint      m_rem [NCH];
    logic [NCH-1:0] exp_p;
    bit          exp_a2;

    function automatic bit crossed(logic [63:0] prev, logic [63:0] cur, logic [63:0] a);
        return (prev < a) && (cur >= a);
    endfunction

    always @(posedge clk) begin
        bit h1, h2, rearm;
        if (!rst_n) begin
            m_en = 0; m_vld = 0; m_a1 = 0; m_a2 = 0; m_prev = 0;
            m_a1lo = 0; m_a2lo = 0; exp_p = '0; exp_a2 = 0;
            for (int i = 0; i < NCH; i++) begin
                m_per[i] = 0; m_run[i] = 0; m_rem[i] = 0;
            end
        end else begin
            h1 = m_vld && !cnt_wr && crossed(m_prev, tns, m_a1);
            h2 = m_vld && !cnt_wr && crossed(m_prev, tns, m_a2);
            rearm = (wr_en && wr_addr == 4'd2) || cnt_wr;
            exp_a2 = h2;
            for (int i = 0; i < NCH; i++) begin
                if (!m_en || rearm) begin
                    m_run[i] = 0; m_rem[i] = 0; exp_p[i] = 0;
                end else if (!m_run[i]) begin
                    exp_p[i] = h1;
                    if (h1) begin m_run[i] = 1; m_rem[i] = longint'(m_per[i]); end
                end else if (m_rem[i] <= 0) begin
                    exp_p[i] = 1; m_rem[i] = m_rem[i] + longint'(m_per[i]);
                end else begin
                    exp_p[i] = 0; m_rem[i] = m_rem[i] - longint'(tick);
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_en = wr_data[0];
                    4'd1: m_a1lo = wr_data;
                    4'd2: m_a1 = {wr_data, m_a1lo};
                    4'd3: m_a2lo = wr_data;
                    4'd4: m_a2 = {wr_data, m_a2lo};
                    4'd5: m_per[0] = wr_data;
                    4'd6: m_per[1] = wr_data;
                    default: ;
                endcase
            end
            m_prev = tns;
            m_vld = 1;
        end
    end

    task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%0h exp=%0h at t=%0d", cur_req, what, got, exp, tns);
        end
    endtask

    // One clock: let the edge pass, compare at the falling edge, advance time.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) begin
            chk("pulse", 64'(pulse), 64'(exp_p));
            chk("pps", 64'(pps), 64'(exp_p[0]));
            chk("alarm2", 64'(a2evt), 64'(exp_a2));
        end
        wr_en = 0; cnt_wr = 0;
        tns = tns + 64'(tick);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc();
    endtask

    task automatic set_alarm(bit second, logic [63:0] v);
        wr(second ? 4'd3 : 4'd1, v[31:0]);
        wr(second ? 4'd4 : 4'd2, v[63:32]);
    endtask

    task automatic load(logic [63:0] v);
        tns = v; cnt_wr = 1;
        cyc();
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk); @(negedge clk);
        cur_req = "R1";
        chk("reset pulse", 64'(pulse), 0);
        chk("reset alarm2", 64'(a2evt), 0);
        @(negedge clk);
        rst_n = 1;
        // R3: zero alarms never match while time runs from near zero.
        cur_req = "R1 R3";
        tns = 0;
        run(20);

        // R5: enable off, alarm crossing gives no pulses.
        cur_req = "R5 R2";
        wr(4'd5, 32'd92);
        wr(4'd6, 32'd40);
        set_alarm(0, tns + 64'd80);
        run(30);

        // R5 R6 R7 R8: armed, aligned start, two periods; R4 alarm 2 strobe.
        cur_req = "R5 R6 R7 R8 R4";
        wr(4'd0, 32'd1);
        set_alarm(0, tns + 64'd160);
        set_alarm(1, tns + 64'd400);
        run(150);

        // R9: disable stops, re-enable waits for a new crossing.
        cur_req = "R9";
        wr(4'd0, 32'd0);
        run(10);
        wr(4'd0, 32'd1);
        run(40);
        set_alarm(0, tns + 64'd64);
        run(40);

        // R10: load backwards re-arms; crossing again restarts.
        cur_req = "R10";
        load(tns - 64'd200);
        run(60);
        // R3: a load that jumps past the alarm is no crossing.
        cur_req = "R3 R10";
        set_alarm(0, tns + 64'd400);
        load(tns + 64'd1000);
        run(30);

        // R11: a low-word write alone leaves alarm 1 where it was.
        cur_req = "R11";
        set_alarm(0, tns + 64'd120);
        wr(4'd1, tns[31:0] + 32'd8);
        run(60);

        // Random runs across the 32-bit word boundary.
        cur_req = "R3 R4 R6 R7 R8 R10";
        for (int it = 0; it < 30; it++) begin
            int unsigned t, d0, d1;
            case ($urandom % 5)
                0: t = 4; 1: t = 8; 2: t = 10; 3: t = 16; default: t = 25;
            endcase
            tick = t;
            d0 = t * (3 + $urandom % 20) + $urandom % t;
            d1 = t * (3 + $urandom % 20) + $urandom % t;
            wr(4'd5, d0 - t);
            wr(4'd6, d1 - t);
            if ($urandom % 3 == 0) load(64'hFFFF_FF00 + 64'($urandom % 128));
            wr(4'd0, ($urandom % 6 == 0) ? 32'd0 : 32'd1);
            set_alarm(0, tns + 64'(t * (3 + $urandom % 10)) - 64'(t));
            if ($urandom % 2 == 0) set_alarm(1, tns + 64'($urandom % 800));
            run(150 + $urandom % 100);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired in %s got=hung exp=done", cur_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule